// File: doc/BRIEF.md
# Register-Configured Video Test Pattern Generator

The block produces a raster of video timing (horizontal sync, vertical sync and a blanking flag) together with 24-bit RGB pixel data. It draws one of four test images inside a programmable rectangular window: horizontal stripes, vertical stripes, a two-colour checkerboard, or a flat fill. Stripe thickness, the first colour and the colour step applied from one stripe to the next are held in a small register bank. A simple write port loads that bank. Active size, porches and sync widths are elaboration-time parameters. The defaults are a tiny raster so that simulation stays short. A 1024x768 mode at a 65 MHz pixel clock is reached by overriding them.

Software lowers `cfg_valid` while it rewrites the bank and raises it again when the set is complete. In the last pixel clock of every frame the timing engine raises an internal frame request. If `cfg_valid` is high at that edge, the whole bank is copied into the working settings, and the copy drives every pixel of the next frame. If it is low, the working settings are kept. A frame is therefore never drawn with a half-written set of registers.

The timing engine has two four-state machines, one horizontal and one vertical, each with the states PH_ACTIVE, PH_FRONT, PH_SYNC and PH_BACK. The horizontal machine moves PH_ACTIVE→PH_FRONT on the last active pixel, PH_FRONT→PH_SYNC on the last front-porch pixel, PH_SYNC→PH_BACK on the last sync pixel, and PH_BACK→PH_ACTIVE on the last pixel of the line. The vertical machine takes the same transitions, but only on line ends and counted in lines.

Top module: `test_pattern_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `blank` is 1, both syncs are at their inactive level and RGB is 0. Reset settings have an empty window, so the first frame after reset is entirely black.
- R2: Lines have a total length of H_ACTIVE+H_FRONT+H_SYNC+H_BACK clocks. Horizontal position 0 is the first active pixel. `hsync` is at SYNC_LEVEL for positions H_ACTIVE+H_FRONT up to but not including H_ACTIVE+H_FRONT+H_SYNC. `blank` is 1 whenever the horizontal position is at or beyond H_ACTIVE. Outputs show position p on the clock after the counter holds p, and the first output after reset shows position (0,0).
- R3: Frames have a total of V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines. `vsync` is at SYNC_LEVEL for whole lines V_ACTIVE+V_FRONT up to but not including V_ACTIVE+V_FRONT+V_SYNC. `blank` is 1 on every line at or beyond V_ACTIVE.
- R4: Register map, by the 3-bit word address:
  - 0: pattern in bits [1:0] (0 horizontal stripes, 1 vertical stripes, 2 checkerboard, 3 flat) and the wrap mode in bit 4.
  - 1: window x start in bits [11:0] and x end (exclusive) in bits [27:16].
  - 2: window y start and end, laid out as in word 1.
  - 3: stripe width in bits [7:0].
  - 4: base colour, with R in [23:16], G in [15:8] and B in [7:0].
  - 5: colour step, with the same packing as word 4.
  - Addresses 6 and 7 are ignored.
- R5: A write changes only the bank. The bank is copied to the working settings at the last clock of a frame when `cfg_valid` is high at that edge, and it takes effect from the first pixel of the next frame. A write on that same edge is not part of the copy.
- R6: If `cfg_valid` is low at the frame-request edge, the previous working settings are used for the whole next frame.
- R7: A pixel is drawn only if x start ≤ h < x end, y start ≤ v < y end, and it lies in the active area. Every other pixel is RGB 0.
- R8: For horizontal stripes the colour is base + n·step per channel, with n = (v − y start) / width.
- R9: For vertical stripes the colour is base + n·step per channel, with n = (h − x start) / width.
- R10: For the checkerboard, let s = (h − x start)/width + (v − y start)/width. The colour is base when s is even and base + step when s is odd.
- R11: The flat pattern (code 3) fills the window with the base colour.
- R12: Each channel sum saturates at 255 when wrap is 0 and is taken modulo 256 when wrap is 1.
- R13: A stripe width of 0 behaves as a width of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_valid | input | 1 | High when the register bank holds a complete set |
| hsync | output | 1 | Horizontal sync, SYNC_LEVEL when active |
| vsync | output | 1 | Vertical sync, SYNC_LEVEL when active |
| blank | output | 1 | 1 outside the active picture |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |

## Verification
Two functions can meet on one clock edge: the frame-boundary handover of settings, and a register write or a change of `cfg_valid`. The bench provokes this by driving a bus write and, separately, a drop of `cfg_valid` into the exact last clock of a frame. It also holds `cfg_valid` low across some boundaries in the random phase. A model in the bench decides whether the bank was copied before or after the write. Every pixel, both syncs and `blank` of the following frame are then compared against colours that the bench computes by division from the requirements.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int COORD_W = 12;
    localparam int SHADE_W = 8;
    localparam int SPAN_W  = 8;
    localparam int RGB_W   = 3 * SHADE_W;

    typedef enum logic [1:0] {
        PAT_LINES   = 2'd0,
        PAT_COLUMNS = 2'd1,
        PAT_CHECKER = 2'd2,
        PAT_SOLID   = 2'd3
    } pattern_e;

    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } phase_e;

    typedef struct packed {
        pattern_e             pattern;
        logic                 wrap;
        logic [COORD_W-1:0]   x_lo;
        logic [COORD_W-1:0]   x_hi;
        logic [COORD_W-1:0]   y_lo;
        logic [COORD_W-1:0]   y_hi;
        logic [SPAN_W-1:0]    span;
        logic [RGB_W-1:0]     base;
        logic [RGB_W-1:0]     step;
    } frame_cfg_t;

    localparam frame_cfg_t CFG_RESET = '0;

    // per-channel add with saturation or modulo behaviour
    function automatic logic [RGB_W-1:0] shade_add(input logic [RGB_W-1:0] a,
                                                   input logic [RGB_W-1:0] b,
                                                   input logic wrap);
        logic [RGB_W-1:0] res;
        logic [SHADE_W:0] sum;
        res = '0;
        for (int c = 0; c < 3; c++) begin
            sum = {1'b0, a[c*SHADE_W +: SHADE_W]} + {1'b0, b[c*SHADE_W +: SHADE_W]};
            if (sum[SHADE_W] && !wrap)
                res[c*SHADE_W +: SHADE_W] = '1;
            else
                res[c*SHADE_W +: SHADE_W] = sum[SHADE_W-1:0];
        end
        return res;
    endfunction

    function automatic logic [SPAN_W:0] span_eff(input logic [SPAN_W-1:0] s);
        return (s == '0) ? (SPAN_W+1)'(1) : {1'b0, s};
    endfunction

endpackage

// File: rtl/tpg_timing.sv
module tpg_timing
    import tpg_pkg::*;
#(
    parameter int H_ACTIVE = 16,
    parameter int H_FRONT  = 2,
    parameter int H_SYNC   = 3,
    parameter int H_BACK   = 3,
    parameter int V_ACTIVE = 12,
    parameter int V_FRONT  = 1,
    parameter int V_SYNC   = 2,
    parameter int V_BACK   = 2
) (
    input  logic               clk,
    input  logic               rst,
    output logic [COORD_W-1:0] hpos,
    output logic [COORD_W-1:0] vpos,
    output logic [COORD_W-1:0] next_h,
    output logic [COORD_W-1:0] next_v,
    output phase_e             hphase,
    output phase_e             vphase,
    output logic               line_end,
    output logic               frame_req
);

    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
    localparam logic [COORD_W-1:0] H_ACT_END = COORD_W'(H_ACTIVE - 1);
    localparam logic [COORD_W-1:0] H_FP_END  = COORD_W'(H_ACTIVE + H_FRONT - 1);
    localparam logic [COORD_W-1:0] H_SY_END  = COORD_W'(H_ACTIVE + H_FRONT + H_SYNC - 1);
    localparam logic [COORD_W-1:0] H_LAST    = COORD_W'(H_TOTAL - 1);
    localparam logic [COORD_W-1:0] V_ACT_END = COORD_W'(V_ACTIVE - 1);
    localparam logic [COORD_W-1:0] V_FP_END  = COORD_W'(V_ACTIVE + V_FRONT - 1);
    localparam logic [COORD_W-1:0] V_SY_END  = COORD_W'(V_ACTIVE + V_FRONT + V_SYNC - 1);
    localparam logic [COORD_W-1:0] V_LAST    = COORD_W'(V_TOTAL - 1);

    logic [COORD_W-1:0] hpos_q, vpos_q;
    phase_e             hphase_q, hphase_d;
    phase_e             vphase_q, vphase_d;

    assign line_end  = (hpos_q == H_LAST);
    assign frame_req = line_end && (vpos_q == V_LAST);
    assign next_h    = line_end ? '0 : hpos_q + 1'b1;
    assign next_v    = !line_end ? vpos_q :
                       ((vpos_q == V_LAST) ? '0 : vpos_q + 1'b1);

    // position counters
    always_ff @(posedge clk) begin
        if (rst) begin
            hpos_q <= '0;
            vpos_q <= '0;
        end else begin
            hpos_q <= next_h;
            vpos_q <= next_v;
        end
    end

    // phase state registers
    always_ff @(posedge clk) begin
        if (rst) begin
            hphase_q <= PH_ACTIVE;
            vphase_q <= PH_ACTIVE;
        end else begin
            hphase_q <= hphase_d;
            vphase_q <= vphase_d;
        end
    end

    // horizontal transitions
    always_comb begin
        hphase_d = hphase_q;
        unique case (hphase_q)
            PH_ACTIVE: if (hpos_q == H_ACT_END) hphase_d = PH_FRONT;
            PH_FRONT:  if (hpos_q == H_FP_END)  hphase_d = PH_SYNC;
            PH_SYNC:   if (hpos_q == H_SY_END)  hphase_d = PH_BACK;
            PH_BACK:   if (line_end)            hphase_d = PH_ACTIVE;
            default:                            hphase_d = PH_ACTIVE;
        endcase
    end

    // vertical transitions, stepped on line ends only
    always_comb begin
        vphase_d = vphase_q;
        if (line_end) begin
            unique case (vphase_q)
                PH_ACTIVE: if (vpos_q == V_ACT_END) vphase_d = PH_FRONT;
                PH_FRONT:  if (vpos_q == V_FP_END)  vphase_d = PH_SYNC;
                PH_SYNC:   if (vpos_q == V_SY_END)  vphase_d = PH_BACK;
                PH_BACK:   if (vpos_q == V_LAST)    vphase_d = PH_ACTIVE;
                default:                            vphase_d = PH_ACTIVE;
            endcase
        end
    end

    assign hpos   = hpos_q;
    assign vpos   = vpos_q;
    assign hphase = hphase_q;
    assign vphase = vphase_q;

    AST_HSYNC_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (hphase_q == PH_SYNC) |-> (hpos_q > H_FP_END && hpos_q <= H_SY_END)); // R2
    AST_HACTIVE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (hphase_q == PH_ACTIVE) |-> (hpos_q <= H_ACT_END)); // R2
    AST_VSYNC_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (vphase_q == PH_SYNC) |-> (vpos_q > V_FP_END && vpos_q <= V_SY_END)); // R3
    AST_WRAP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        frame_req |=> (hpos_q == '0 && vpos_q == '0 && vphase_q == PH_ACTIVE)); // R3

endmodule

// File: rtl/tpg_cfg_bank.sv
module tpg_cfg_bank
    import tpg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        set_ok,
    input  logic        take,
    output frame_cfg_t  act,
    output frame_cfg_t  nx
);

    frame_cfg_t bank_q;
    frame_cfg_t act_q;
    logic       load;

    assign load = take && set_ok;

    // staging registers written by the bus
    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= CFG_RESET;
        end else if (wr_en) begin
            unique case (wr_addr)
                3'd0: begin
                    bank_q.pattern <= pattern_e'(wr_data[1:0]);
                    bank_q.wrap    <= wr_data[4];
                end
                3'd1: begin
                    bank_q.x_lo <= wr_data[COORD_W-1:0];
                    bank_q.x_hi <= wr_data[16 +: COORD_W];
                end
                3'd2: begin
                    bank_q.y_lo <= wr_data[COORD_W-1:0];
                    bank_q.y_hi <= wr_data[16 +: COORD_W];
                end
                3'd3: bank_q.span <= wr_data[SPAN_W-1:0];
                3'd4: bank_q.base <= wr_data[RGB_W-1:0];
                3'd5: bank_q.step <= wr_data[RGB_W-1:0];
                default: ;
            endcase
        end
    end

    // working set, replaced only at the frame boundary
    always_ff @(posedge clk) begin
        if (rst)
            act_q <= CFG_RESET;
        else if (load)
            act_q <= bank_q;
    end

    assign act = act_q;
    assign nx  = load ? bank_q : act_q;

    AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(act_q)); // R5
    AST_HOLD_INVALID: assert property (@(posedge clk) disable iff (rst)
        (take && !set_ok) |=> $stable(act_q)); // R6
    AST_LOAD_ON_VALID: assert property (@(posedge clk) disable iff (rst)
        (take && set_ok) |=> (act_q == $past(bank_q))); // R5

endmodule

// File: rtl/tpg_pixel.sv
module tpg_pixel
    import tpg_pkg::*;
#(
    parameter logic SYNC_LEVEL = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [COORD_W-1:0] hpos,
    input  logic [COORD_W-1:0] vpos,
    input  logic [COORD_W-1:0] next_h,
    input  logic [COORD_W-1:0] next_v,
    input  logic               line_end,
    input  phase_e             hphase,
    input  phase_e             vphase,
    input  frame_cfg_t         act,
    input  frame_cfg_t         nx,
    output logic               o_hsync,
    output logic               o_vsync,
    output logic               o_blank,
    output logic [RGB_W-1:0]   o_rgb
);

    logic [SPAN_W-1:0] xcnt, ycnt;
    logic [RGB_W-1:0]  xcol, ycol;
    logic              xpar, ypar;
    logic [SPAN_W:0]   nx_span;
    logic [SPAN_W:0]   xinc, yinc;
    logic              in_act, in_roi;
    logic [RGB_W-1:0]  alt_col;
    logic [RGB_W-1:0]  pix;

    assign nx_span = span_eff(nx.span);
    assign xinc    = {1'b0, xcnt} + (SPAN_W+1)'(1);
    assign yinc    = {1'b0, ycnt} + (SPAN_W+1)'(1);

    // column tracker: state for the pixel now on the counters
    always_ff @(posedge clk) begin
        if (rst) begin
            xcnt <= '0;
            xcol <= CFG_RESET.base;
            xpar <= 1'b0;
        end else if (next_h <= nx.x_lo) begin
            xcnt <= '0;
            xcol <= nx.base;
            xpar <= 1'b0;
        end else if (xinc >= nx_span) begin
            xcnt <= '0;
            xcol <= shade_add(xcol, nx.step, nx.wrap);
            xpar <= ~xpar;
        end else begin
            xcnt <= xinc[SPAN_W-1:0];
        end
    end

    // row tracker: stepped once per line
    always_ff @(posedge clk) begin
        if (rst) begin
            ycnt <= '0;
            ycol <= CFG_RESET.base;
            ypar <= 1'b0;
        end else if (line_end) begin
            if (next_v <= nx.y_lo) begin
                ycnt <= '0;
                ycol <= nx.base;
                ypar <= 1'b0;
            end else if (yinc >= nx_span) begin
                ycnt <= '0;
                ycol <= shade_add(ycol, nx.step, nx.wrap);
                ypar <= ~ypar;
            end else begin
                ycnt <= yinc[SPAN_W-1:0];
            end
        end
    end

    assign in_act  = (hphase == PH_ACTIVE) && (vphase == PH_ACTIVE);
    assign in_roi  = (hpos >= act.x_lo) && (hpos < act.x_hi) &&
                     (vpos >= act.y_lo) && (vpos < act.y_hi);
    assign alt_col = shade_add(act.base, act.step, act.wrap);

    always_comb begin
        pix = '0;
        if (in_act && in_roi) begin
            unique case (act.pattern)
                PAT_LINES:   pix = ycol;
                PAT_COLUMNS: pix = xcol;
                PAT_CHECKER: pix = (xpar ^ ypar) ? alt_col : act.base;
                PAT_SOLID:   pix = act.base;
                default:     pix = '0;
            endcase
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            o_hsync <= ~SYNC_LEVEL;
            o_vsync <= ~SYNC_LEVEL;
            o_blank <= 1'b1;
            o_rgb   <= '0;
        end else begin
            o_hsync <= (hphase == PH_SYNC) ? SYNC_LEVEL : ~SYNC_LEVEL;
            o_vsync <= (vphase == PH_SYNC) ? SYNC_LEVEL : ~SYNC_LEVEL;
            o_blank <= !in_act;
            o_rgb   <= pix;
        end
    end

    AST_BLACK_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        o_blank |-> (o_rgb == '0)); // R7
    AST_HSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        (o_hsync == SYNC_LEVEL) |-> o_blank); // R2
    AST_VSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        (o_vsync == SYNC_LEVEL) |-> o_blank); // R3
    AST_SOLID_IS_BASE: assert property (@(posedge clk) disable iff (rst)
        (in_act && in_roi && act.pattern == PAT_SOLID) |=> (o_rgb == $past(act.base))); // R11

endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen
    import tpg_pkg::*;
#(
    parameter int   H_ACTIVE   = 16,
    parameter int   H_FRONT    = 2,
    parameter int   H_SYNC     = 3,
    parameter int   H_BACK     = 3,
    parameter int   V_ACTIVE   = 12,
    parameter int   V_FRONT    = 1,
    parameter int   V_SYNC     = 2,
    parameter int   V_BACK     = 2,
    parameter logic SYNC_LEVEL = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        cfg_valid,
    output logic        hsync,
    output logic        vsync,
    output logic        blank,
    output logic [7:0]  red,
    output logic [7:0]  green,
    output logic [7:0]  blue
);

    logic [COORD_W-1:0] hpos, vpos, next_h, next_v;
    phase_e             hphase, vphase;
    logic               line_end, frame_req;
    frame_cfg_t         act, nx;
    logic [RGB_W-1:0]   rgb;

    tpg_timing #(
        .H_ACTIVE (H_ACTIVE), .H_FRONT (H_FRONT), .H_SYNC (H_SYNC), .H_BACK (H_BACK),
        .V_ACTIVE (V_ACTIVE), .V_FRONT (V_FRONT), .V_SYNC (V_SYNC), .V_BACK (V_BACK)
    ) u_timing (
        .clk       (clk),
        .rst       (rst),
        .hpos      (hpos),
        .vpos      (vpos),
        .next_h    (next_h),
        .next_v    (next_v),
        .hphase    (hphase),
        .vphase    (vphase),
        .line_end  (line_end),
        .frame_req (frame_req)
    );

    tpg_cfg_bank u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .set_ok  (cfg_valid),
        .take    (frame_req),
        .act     (act),
        .nx      (nx)
    );

    tpg_pixel #(
        .SYNC_LEVEL (SYNC_LEVEL)
    ) u_pixel (
        .clk      (clk),
        .rst      (rst),
        .hpos     (hpos),
        .vpos     (vpos),
        .next_h   (next_h),
        .next_v   (next_v),
        .line_end (line_end),
        .hphase   (hphase),
        .vphase   (vphase),
        .act      (act),
        .nx       (nx),
        .o_hsync  (hsync),
        .o_vsync  (vsync),
        .o_blank  (blank),
        .o_rgb    (rgb)
    );

    assign red   = rgb[2*SHADE_W +: SHADE_W];
    assign green = rgb[SHADE_W +: SHADE_W];
    assign blue  = rgb[0 +: SHADE_W];

endmodule

// File: tb/test_pattern_gen_tb.sv
module test_pattern_gen_tb;

    localparam int HA = 16, HF = 2, HS = 3, HB = 3;
    localparam int VA = 12, VF = 1, VS = 2, VB = 2;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam logic SL = 1'b0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_valid = 1'b1;
    logic        hsync, vsync, blank;
    logic [7:0]  red, green, blue;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    string phase_tag = "R1";

    test_pattern_gen #(
        .H_ACTIVE (HA), .H_FRONT (HF), .H_SYNC (HS), .H_BACK (HB),
        .V_ACTIVE (VA), .V_FRONT (VF), .V_SYNC (VS), .V_BACK (VB),
        .SYNC_LEVEL (SL)
    ) u_dut (
        .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .cfg_valid (cfg_valid),
        .hsync (hsync), .vsync (vsync), .blank (blank),
        .red (red), .green (green), .blue (blue)
    );

    always #10 clk = ~clk;

    // ---------------- bench model ----------------
    logic [31:0] bank_m [0:5];
    logic [31:0] act_m  [0:5];
    int mh = 0, mv = 0;
    int eh = 0, ev = 0;
    bit exp_ok = 0;
    logic [23:0] exp_rgb;
    logic exp_blank, exp_hs, exp_vs;

    function automatic logic [23:0] grow(logic [23:0] b, logic [23:0] s, int n, bit wr);
        logic [23:0] r;
        for (int c = 0; c < 3; c++) begin
            int sum;
            sum = int'(b[c*8 +: 8]) + n * int'(s[c*8 +: 8]);
            r[c*8 +: 8] = wr ? 8'(sum % 256) : ((sum > 255) ? 8'hFF : 8'(sum));
        end
        return r;
    endfunction

    function automatic logic [23:0] model_rgb(int h, int v);
        int x0, x1, y0, y1, w, pat, n;
        bit wr;
        logic [23:0] b, s;
        pat = int'(act_m[0][1:0]);
        wr  = act_m[0][4];
        x0 = int'(act_m[1][11:0]);  x1 = int'(act_m[1][27:16]);
        y0 = int'(act_m[2][11:0]);  y1 = int'(act_m[2][27:16]);
        w  = (act_m[3][7:0] == 0) ? 1 : int'(act_m[3][7:0]);   // R13
        b  = act_m[4][23:0];
        s  = act_m[5][23:0];
        if (!(h < HA && v < VA)) return 24'h0;
        if (!(h >= x0 && h < x1 && v >= y0 && v < y1)) return 24'h0;  // R7
        case (pat)
            0: begin n = (v - y0) / w; return grow(b, s, n, wr); end           // R8
            1: begin n = (h - x0) / w; return grow(b, s, n, wr); end           // R9
            2: begin n = ((h - x0) / w + (v - y0) / w) % 2;                     // R10
                     return (n == 1) ? grow(b, s, 1, wr) : b; end
            default: return b;                                                  // R11
        endcase
    endfunction

    function automatic string pix_tag(int h, int v);
        int pat;
        pat = int'(act_m[0][1:0]);
        if (!(h < HA && v < VA)) return "R2";
        if (!(h >= int'(act_m[1][11:0]) && h < int'(act_m[1][27:16]) &&
              v >= int'(act_m[2][11:0]) && v < int'(act_m[2][27:16]))) return "R7";
        case (pat)
            0: return act_m[0][4] ? "R8/R12" : "R8";
            1: return act_m[0][4] ? "R9/R12" : "R9";
            2: return "R10";
            default: return "R11";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mh = 0; mv = 0; exp_ok = 0;
            for (int i = 0; i < 6; i++) begin bank_m[i] = '0; act_m[i] = '0; end
        end else begin
            eh = mh; ev = mv;
            exp_rgb   = model_rgb(mh, mv);
            exp_blank = !(mh < HA && mv < VA);
            exp_hs    = (mh >= HA + HF && mh < HA + HF + HS) ? SL : ~SL;
            exp_vs    = (mv >= VA + VF && mv < VA + VF + VS) ? SL : ~SL;
            exp_ok    = 1;
            if (mh == HT - 1 && mv == VT - 1 && cfg_valid)
                for (int i = 0; i < 6; i++) act_m[i] = bank_m[i];       // R5
            if (cfg_we && cfg_addr < 3'd6) bank_m[cfg_addr] = cfg_wdata;  // R4
            if (mh == HT - 1) begin
                mh = 0;
                mv = (mv == VT - 1) ? 0 : mv + 1;
            end else begin
                mh = mh + 1;
            end
        end
    end

    task automatic finish_sim();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (exp_ok && !done) begin
            checks++;
            if ({red, green, blue} !== exp_rgb) begin
                errors++;
                $display("FAIL %s (phase %s) rgb h=%0d v=%0d got %h exp %h",
                         pix_tag(eh, ev), phase_tag, eh, ev, {red, green, blue}, exp_rgb);
            end
            checks++;
            if (blank !== exp_blank || hsync !== exp_hs) begin
                errors++;
                $display("FAIL R2 h=%0d v=%0d blank/hsync got %b%b exp %b%b",
                         eh, ev, blank, hsync, exp_blank, exp_hs);
            end
            checks++;
            if (vsync !== exp_vs) begin
                errors++;
                $display("FAIL R3 v=%0d vsync got %b exp %b", ev, vsync, exp_vs);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog expired: got running exp finished");
            finish_sim();
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // returns at the negedge inside the last clock of a frame
    task automatic to_req();
        do @(negedge clk); while (!(mh == HT - 1 && mv == VT - 1));
    endtask

    task automatic load(input int pat, input bit wrp, input int x0, input int x1,
                        input int y0, input int y1, input int span,
                        input logic [23:0] b, input logic [23:0] s, input bit keep);
        @(negedge clk);
        cfg_valid = 1'b0;
        wr(3'd0, {27'd0, wrp, 2'b00, 2'(pat)});
        wr(3'd1, {4'd0, 12'(x1), 4'd0, 12'(x0)});
        wr(3'd2, {4'd0, 12'(y1), 4'd0, 12'(y0)});
        wr(3'd3, {24'd0, 8'(span)});
        wr(3'd4, {8'd0, b});
        wr(3'd5, {8'd0, s});
        wr(3'd6, 32'hFFFF_FFFF);   // R4: unmapped word, no effect
        cfg_valid = keep;
    endtask

    task automatic next_frame(input string tag);
        to_req();
        @(negedge clk);
        phase_tag = tag;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        checks++;
        if (blank !== 1'b1 || hsync !== ~SL || vsync !== ~SL || {red, green, blue} !== 24'h0) begin
            errors++;
            $display("FAIL R1 reset outputs got %b%b%b %h exp 1%b%b 000000",
                     blank, hsync, vsync, {red, green, blue}, ~SL, ~SL);
        end
        rst = 1'b0;
        // first frame: reset settings, all black (R1)
        load(0, 0, 0, HA, 0, VA, 2, 24'h102030, 24'h080808, 1);
        next_frame("R8");                                            // R4, R8
        load(1, 0, 2, 14, 1, 11, 3, 24'hF0_10_80, 24'h30_05_40, 1);
        next_frame("R9");                                            // R9, R12 saturate
        load(1, 1, 0, HA, 0, VA, 2, 24'hF0_10_80, 24'h30_05_40, 1);
        next_frame("R12");                                           // R12 wrap
        load(2, 0, 3, 13, 2, 10, 2, 24'h204060, 24'h101010, 1);
        next_frame("R10");
        load(3, 0, 5, 9, 4, 7, 1, 24'hABCDEF, 24'h0, 1);
        next_frame("R11");                                           // R7 small window
        load(0, 0, 0, HA, 0, VA, 0, 24'h000000, 24'h0C0C0C, 1);
        next_frame("R13");
        // R6: set left invalid across the boundary
        load(2, 1, 0, HA, 0, VA, 1, 24'h111111, 24'hF0F0F0, 0);
        next_frame("R6");
        cfg_valid = 1'b1;
        // R5: write on the request edge is not part of the copy
        load(3, 0, 0, HA, 0, VA, 1, 24'h445566, 24'h0, 1);
        to_req();
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 32'h00_99_88_77;
        @(negedge clk);
        cfg_we = 1'b0;
        phase_tag = "R5";
        // R5/R6: valid dropped exactly in the request clock
        to_req();
        cfg_valid = 1'b0;
        @(negedge clk);
        phase_tag = "R6";
        cfg_valid = 1'b1;
        next_frame("R5");
        // constrained random frames
        for (int f = 0; f < 30; f++) begin
            bit keep;
            keep = ($urandom_range(0, 3) != 0);
            load($urandom_range(0, 3), 1'($urandom_range(0, 1)),
                 $urandom_range(0, HA), $urandom_range(0, HA + 2),
                 $urandom_range(0, VA), $urandom_range(0, VA + 2),
                 $urandom_range(0, 5), 24'($urandom),
                 ($urandom_range(0, 1) != 0) ? 24'($urandom) : 24'($urandom & 32'h0F0F0F),
                 keep);
            next_frame(keep ? "R7" : "R6");
            cfg_valid = 1'b1;
        end
        next_frame("R5");
        to_req();
        repeat (2) @(negedge clk);
        finish_sim();
    end

endmodule